// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Queue

This block sits on the inbound path of a PCIe root-port bridge. Every inbound memory write arrives on a simple valid/ready port with a 64-bit address and a 32-bit data word. The block compares the address against a programmable window. A write that lands in the window while capture is switched on is stored in a 16-entry queue as one message: the data word together with both halves of the address. Writes outside the window are accepted and discarded.

Software reaches the block through a 32-bit APB-style register slave. It sets the window base and size, switches capture on, and retires messages by reading the head entry's data, low address and high address registers. A shared level interrupt combines a message-pending flag with four legacy interrupt sources. Each of these flags has its own enable bit, and software clears a flag by writing a 1 to it.

A vector number v is normally sent as data v to address base + 4·v.

Top module: `msi_capture_fifo`

## Requirements
- R1: When capture is on, a write is stored if its address lies in [base, base + size), where base = {reg 0x08, reg 0x04} and size = reg 0x0C. Any other write is accepted with in_ready high and is not stored.
- R2: Capture is on only while bit 0 of reg 0x14 is 1. A write that arrives while capture is off is accepted and not stored.
- R3: Status reg 0x18 bit 0 reads 1 while at least one message is queued and 0 when the queue is empty.
- R4: Reg 0x20 returns the head entry's data, reg 0x24 its address bits 31:0 and reg 0x28 its address bits 63:32. The reads may come in any order. The head entry is retired on the access that completes the third distinct read, and not before.
- R5: Messages are returned in arrival order. Up to 16 messages can be held at once.
- R6: While the queue is full, an in-window write with capture on sees in_ready low and is held off, not lost. Such a write also sets sticky bit 1 of reg 0x18, which only a write of 1 to that bit clears.
- R7: While the queue is empty, reads of regs 0x20, 0x24 and 0x28 return 0 and change nothing.
- R8: Reg 0x34 holds the interrupt flags. Bit 3 is the message flag; it sets while the queue is non-empty and a write of 1 clears it only when the queue is empty. Bits 5 to 8 latch intx_req[0] to [3]. Writing 1 to a bit clears it.
- R9: Reg 0x30 enables the flags; only bits 3 and 5 to 8 are writable. irq is high exactly while some flag in reg 0x34 is set with its enable bit in reg 0x30.
- R10: Writing 0 to bit 0 of reg 0x14 empties the queue and abandons any partly read head entry.
- R11: After reset every register reads 0, the queue is empty, irq is 0 and in_ready is 1.
- R12: A write captured while the head entry is partly read does not change the values returned for that head entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Inbound write present |
| in_ready | output | 1 | Inbound write accepted this cycle |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write data |
| psel | input | 1 | Register slave select |
| penable | input | 1 | Register access phase |
| pwrite | input | 1 | 1 = register write, 0 = register read |
| paddr | input | PAW | Register byte offset |
| pwdata | input | 32 | Register write data |
| prdata | output | 32 | Register read data |
| intx_req | input | 4 | Legacy interrupt source levels |
| irq | output | 1 | Shared interrupt request |

## Verification
The hardest case to reach is a three-read pop that is interrupted. After software has read part of the head entry, a new write is captured, and the remaining reads must still return the old head. The bench gets there by reading only the data register, then pushing a second message through the inbound port, then reading the two address halves in the reverse of their offset order. A full queue with a held-off write is reached by pushing sixteen messages with no reads in between and then keeping a seventeenth valid for one cycle.

// File: rtl/msi_capture_fifo.sv
module msi_capture_fifo #(
  parameter int DEPTH = 16,
  parameter int PAW   = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [63:0]    in_addr,
  input  logic [31:0]    in_data,
  input  logic           psel,
  input  logic           penable,
  input  logic           pwrite,
  input  logic [PAW-1:0] paddr,
  input  logic [31:0]    pwdata,
  output logic [31:0]    prdata,
  input  logic [3:0]     intx_req,
  output logic           irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [8:0] EN_MASK = 9'h1E8;

  logic [31:0] base_lo, base_hi, win_size;
  logic        en_q, ovf_q;
  logic [8:0]  misc_en_q, misc_stat_q;
  logic [31:0] data_mem [DEPTH];
  logic [31:0] alo_mem  [DEPTH];
  logic [31:0] ahi_mem  [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [PW:0]   count;
  logic [2:0]    seen_q;

  wire acc    = psel && penable;
  wire wr_acc = acc && pwrite;
  wire rd_acc = acc && !pwrite;

  wire [63:0] base = {base_hi, base_lo};
  wire [63:0] offs = in_addr - base;
  wire hit   = (in_addr >= base) && (offs < {32'd0, win_size});
  wire want  = in_valid && en_q && hit;
  wire full  = (count == (PW+1)'(DEPTH));
  wire empty = (count == '0);
  wire push  = want && !full;

  assign in_ready = !(want && full);

  wire [2:0] rd_hit = {rd_acc && paddr == PAW'(8'h28),
                       rd_acc && paddr == PAW'(8'h24),
                       rd_acc && paddr == PAW'(8'h20)} & {3{!empty}};
  wire [2:0] seen_next = seen_q | rd_hit;
  wire pop   = !empty && (&seen_next);
  wire flush = wr_acc && paddr == PAW'(8'h14) && !pwdata[0];

  wire [8:0] w1c  = (wr_acc && paddr == PAW'(8'h34)) ? pwdata[8:0] : 9'd0;
  wire [8:0] mset = {intx_req, 1'b0, !empty, 3'b000};
  wire ovf_clr = wr_acc && paddr == PAW'(8'h18) && pwdata[1];

  assign irq = |(misc_stat_q & misc_en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_lo     <= '0;
      base_hi     <= '0;
      win_size    <= '0;
      en_q        <= 1'b0;
      ovf_q       <= 1'b0;
      misc_en_q   <= '0;
      misc_stat_q <= '0;
      wr_ptr      <= '0;
      rd_ptr      <= '0;
      count       <= '0;
      seen_q      <= '0;
    end else begin
      if (wr_acc) begin
        case (paddr)
          PAW'(8'h04): base_lo   <= pwdata;
          PAW'(8'h08): base_hi   <= pwdata;
          PAW'(8'h0C): win_size  <= pwdata;
          PAW'(8'h14): en_q      <= pwdata[0];
          PAW'(8'h30): misc_en_q <= pwdata[8:0] & EN_MASK;
          default: ;
        endcase
      end
      if (want && full)  ovf_q <= 1'b1;
      else if (ovf_clr)  ovf_q <= 1'b0;
      misc_stat_q <= (misc_stat_q & ~w1c) | mset;
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        count  <= '0;
        seen_q <= '0;
      end else begin
        if (push) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + PW'(1);
        if (pop) begin
          rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + PW'(1);
          seen_q <= '0;
        end else begin
          seen_q <= seen_next;
        end
        count <= count + (PW+1)'(push) - (PW+1)'(pop);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) begin
      data_mem[wr_ptr] <= in_data;
      alo_mem[wr_ptr]  <= in_addr[31:0];
      ahi_mem[wr_ptr]  <= in_addr[63:32];
    end
  end

  always_comb begin
    prdata = '0;
    case (paddr)
      PAW'(8'h04): prdata = base_lo;
      PAW'(8'h08): prdata = base_hi;
      PAW'(8'h0C): prdata = win_size;
      PAW'(8'h14): prdata = {31'd0, en_q};
      PAW'(8'h18): prdata = {30'd0, ovf_q, !empty};
      PAW'(8'h20): prdata = empty ? '0 : data_mem[rd_ptr];
      PAW'(8'h24): prdata = empty ? '0 : alo_mem[rd_ptr];
      PAW'(8'h28): prdata = empty ? '0 : ahi_mem[rd_ptr];
      PAW'(8'h30): prdata = {23'd0, misc_en_q};
      PAW'(8'h34): prdata = {23'd0, misc_stat_q};
      default: ;
    endcase
  end
endmodule

// File: rtl/msi_capture_fifo_chk.sv
module msi_capture_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int PAW   = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           psel,
  input logic           penable,
  input logic           pwrite,
  input logic [PAW-1:0] paddr,
  input logic [1:0]     pwdata_lo,
  input logic           en_q,
  input logic           ovf_q,
  input logic [PW:0]    count,
  input logic [8:0]     misc_stat_q
);
  wire wr_acc = psel && penable && pwrite;

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (PW+1)'(DEPTH));

  p_msi_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0) |=> misc_stat_q[3]);

  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && paddr == PAW'(8'h14) && !pwdata_lo[0]) |=> (count == '0));

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(wr_acc && paddr == PAW'(8'h18) && pwdata_lo[1])) |=> ovf_q);

  p_off_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (count == '0));
endmodule

bind msi_capture_fifo msi_capture_fifo_chk #(.DEPTH(DEPTH), .PAW(PAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata_lo(pwdata[1:0]), .en_q(en_q), .ovf_q(ovf_q),
  .count(count), .misc_stat_q(misc_stat_q));

// File: tb/msi_capture_fifo_bench.sv
module msi_capture_fifo_bench;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0;
  logic in_ready;
  logic [63:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic [3:0] intx_req = '0;
  logic irq;

  int checks = 0, errors = 0, cycles = 0;
  bit  tb_en = 0;
  logic [63:0] tb_base = '0;
  logic [31:0] tb_size = '0;
  logic [95:0] sb[$];

  msi_capture_fifo u_msi_capture_fifo (.*);

  always #10 clk = ~clk;

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
      summary();
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apb(bit wr, logic [7:0] a, logic [31:0] d, output logic [31:0] r);
    @(negedge clk); psel = 1; pwrite = wr; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1; #1 r = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic wreg(logic [7:0] a, logic [31:0] d);
    logic [31:0] r;
    apb(1, a, d, r);
    if (a == 8'h14) begin
      tb_en = d[0];
      if (!d[0]) sb.delete();
    end
  endtask

  task automatic rreg(logic [7:0] a, output logic [31:0] r);
    apb(0, a, 0, r);
  endtask

  // driver: one inbound handshake, expected item queued when it should be kept
  task automatic send(logic [63:0] a, logic [31:0] d);
    int guard = 0;
    @(negedge clk); in_valid = 1; in_addr = a; in_data = d;
    #1;
    while (!in_ready && guard < 50) begin @(negedge clk); #1; guard++; end
    @(negedge clk); in_valid = 0;
    if (tb_en && a >= tb_base && (a - tb_base) < {32'd0, tb_size})
      sb.push_back({a, d});
  endtask

  // monitor: three reads in a chosen order, compared with the queue head
  task automatic drain(string req, int order);
    logic [31:0] d, lo, hi;
    logic [95:0] e;
    if (order == 0) begin rreg(8'h20, d); rreg(8'h24, lo); rreg(8'h28, hi); end
    else begin rreg(8'h28, hi); rreg(8'h20, d); rreg(8'h24, lo); end
    if (sb.size() == 0) begin
      check({req, " scoreboard empty"}, 1, 0);
    end else begin
      e = sb.pop_front();
      check(req, {hi, lo, d}, {e[95:64], e[63:32], e[31:0]});
    end
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check("R11 irq", irq, 0);
    check("R11 ready", in_ready, 1);
    rreg(8'h18, r); check("R11 status", r, 0);
    rreg(8'h04, r); check("R11 base", r, 0);
    rreg(8'h34, r); check("R11 misc", r, 0);

    tb_base = 64'h0000_0001_2340_0000; tb_size = 4096;
    wreg(8'h04, tb_base[31:0]); wreg(8'h08, tb_base[63:32]); wreg(8'h0C, tb_size);
    send(tb_base + 8, 2);
    rreg(8'h18, r); check("R2 disabled write dropped", r, 0);

    wreg(8'h14, 1);
    send(tb_base + 20, 5);
    send(tb_base + 4096, 77);
    send(tb_base - 4, 78);
    rreg(8'h18, r); check("R3 status pending", r, 1);
    rreg(8'h34, r); check("R8 msi flag set", r[3], 1);
    @(negedge clk); #1 check("R9 irq masked", irq, 0);
    wreg(8'h30, 32'hFFFF_FFFF);
    rreg(8'h30, r); check("R9 enable mask", r, 32'h1E8);
    #1 check("R9 irq raised", irq, 1);

    // R4: partial read keeps entry
    rreg(8'h20, r); check("R4 data", r, 5);
    rreg(8'h18, r); check("R4 still pending after data", r, 1);
    rreg(8'h20, r); check("R4 repeat data no pop", r, 5);
    rreg(8'h28, r); check("R4 hi", r, tb_base[63:32]);
    rreg(8'h18, r); check("R4 still pending after two", r, 1);
    rreg(8'h24, r); check("R4 lo", r, tb_base[31:0] + 20);
    rreg(8'h18, r); check("R4 retired", r, 0);
    void'(sb.pop_front());
    rreg(8'h24, r); check("R1 out-of-window not stored", r, 0);

    // R7 empty reads
    rreg(8'h20, r); check("R7 empty data", r, 0);
    rreg(8'h28, r); check("R7 empty hi", r, 0);
    rreg(8'h18, r); check("R7 status unchanged", r, 0);

    // R8 w1c only when empty
    rreg(8'h34, r); check("R8 flag held after empty", r[3], 1);
    wreg(8'h34, 32'h8);
    rreg(8'h34, r); check("R8 flag cleared", r[3], 0);
    #1 check("R9 irq low", irq, 0);

    // R12: capture during partial pop
    send(tb_base + 12, 3);
    wreg(8'h34, 32'h8);
    rreg(8'h34, r); check("R8 w1c ignored while pending", r[3], 1);
    rreg(8'h20, r); check("R12 head data", r, 3);
    send(tb_base + 36, 9);
    rreg(8'h28, r); check("R12 head hi", r, tb_base[63:32]);
    rreg(8'h24, r); check("R12 head lo", r, tb_base[31:0] + 12);
    void'(sb.pop_front());
    drain("R12 next entry", 1);

    // R5/R6 full queue
    for (int i = 0; i < 16; i++) send(tb_base + 64'(4*i), 32'(i));
    rreg(8'h18, r); check("R6 no ovf yet", r, 1);
    @(negedge clk); in_valid = 1; in_addr = tb_base + 100; in_data = 99;
    #1 check("R6 ready low when full", in_ready, 0);
    @(negedge clk); in_valid = 0;
    rreg(8'h18, r); check("R6 ovf sticky", r, 3);
    for (int i = 0; i < 16; i++) drain("R5 order", i % 2);
    rreg(8'h18, r); check("R5 drained, ovf kept", r, 2);
    wreg(8'h18, 2);
    rreg(8'h18, r); check("R6 ovf cleared", r, 0);

    // R10 flush
    send(tb_base + 4, 1); send(tb_base + 8, 2);
    rreg(8'h20, r);
    wreg(8'h14, 0);
    rreg(8'h18, r); check("R10 flushed", r, 0);
    wreg(8'h14, 1);
    rreg(8'h20, r); check("R10 no stale data", r, 0);
    send(tb_base + 28, 7);
    drain("R10 fresh entry after flush", 0);

    // R8/R9 legacy sources
    wreg(8'h34, 32'h1FF);
    @(negedge clk); intx_req = 4'b0100;
    @(negedge clk); intx_req = 0;
    rreg(8'h34, r); check("R8 intx latched", r, 32'h80);
    #1 check("R9 irq from intx", irq, 1);
    wreg(8'h34, 32'h80);
    rreg(8'h34, r); check("R8 intx cleared", r, 0);
    #1 check("R9 irq dropped", irq, 0);
    check("R5 scoreboard empty", sb.size(), 0);
    summary();
  end
endmodule